// File: doc/BRIEF.md
# Invert-Controlled Arithmetic-Logic Unit

This is a purely combinational arithmetic-logic unit with a configurable data width, 32 bits by default. A four-bit control word drives it. The top two bits of the word can invert either operand. The bottom two bits pick one of four result paths: bitwise AND, bitwise OR, the adder sum, or a signed less-than comparison. Subtract is the adder with operand B inverted and a carry-in of one. NOR is the AND path with both operands inverted. This keeps the result multiplexer at four inputs and leaves a single adder in the design.

Next to the result, the block reports two flags. A zero flag tells a branch unit whether two values were equal after a subtract. A signed-overflow flag lets the surrounding pipeline raise an arithmetic exception. There is no decoding, state or clock inside: the block expects a finished control word from the caller.

Top module: `inv_ctl_alu`

## Requirements
- R1: Control word field layout: bit 3 inverts operand A and bit 2 inverts operand B. Bit 2 also supplies the adder carry-in. Bits 1:0 select the path: 00 AND, 01 OR, 10 sum, 11 less-than.
- R2: Code 0010 gives A + B modulo 2^WIDTH.
- R3: Code 0110 gives A - B in two's complement.
- R4: Code 0000 gives A & B, and code 0001 gives A | B.
- R5: Code 1100 gives ~(A | B).
- R6: Code 0111 gives 1 in bit 0 when signed A is less than signed B, otherwise 0. This holds even when A - B overflows. All upper bits are 0.
- R7: `zero_o` is 1 exactly when every result bit is 0. A subtract of equal operands therefore raises it.
- R8: `ovf_o` follows signed overflow for codes 0010 and 0110. It is 1 when both adder inputs, after inversion, have the same sign and the sum's sign differs from it.
- R9: `ovf_o` is 0 for every code other than 0010 and 0110.
- R10: For unlisted codes, the result still comes from the same datapath. Let A' and B' be the operands after the bit 3 and bit 2 inversions. The sum is A' + B' + bit 2. The result is then A' & B', A' | B', that sum, or {0, sum sign XOR raw overflow}, according to bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctrl_i | input | 4 | Control word {invert A, invert B, path select[1:0]} |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | High when the result is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
Every output is due in the same cycle as its stimulus, because no register sits between the operands and the result or flags. The bench applies each input set on a falling clock edge. It samples `result_o`, `zero_o` and `ovf_o` one nanosecond later, which lets the combinational paths settle well before the next rising edge. Expected values come from plain signed and unsigned arithmetic on the operands. Unlisted codes are the exception: for them, R10 itself gives the formula.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      SEL_AND = 2'b00,
      SEL_OR  = 2'b01,
      SEL_SUM = 2'b10,
      SEL_LT  = 2'b11
   } sel_e;

   localparam logic [3:0] CW_ADD = 4'b0010;
   localparam logic [3:0] CW_SUB = 4'b0110;

   function automatic logic is_arith(input logic [3:0] cw);
      return (cw == CW_ADD) || (cw == CW_SUB);
   endfunction
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_a_i,
   input  logic             inv_b_i,
   output logic [WIDTH-1:0] a_o,
   output logic [WIDTH-1:0] b_o
);
   assign a_o = inv_a_i ? ~a_i : a_i;
   assign b_o = inv_b_i ? ~b_i : b_i;
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH  = 32,
   parameter int RIPPLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (RIPPLE != 0) begin : g_ripple
         logic [WIDTH-1:0] carry;
         assign carry[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ carry[i];
            if (i < WIDTH - 1) begin : g_c
               assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
            end
         end
      end else begin : g_flat
         assign sum_o = a_i + b_i + {{(WIDTH-1){1'b0}}, cin_i};
      end
   endgenerate

   assign ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] sum_i,
   input  logic             ovf_raw_i,
   input  sel_e             sel_i,
   output logic [WIDTH-1:0] result_o
);
   localparam int MSB = WIDTH - 1;

   logic lt_bit;
   assign lt_bit = sum_i[MSB] ^ ovf_raw_i;

   always_comb begin
      unique case (sel_i)
         SEL_AND: result_o = a_i & b_i;
         SEL_OR:  result_o = a_i | b_i;
         SEL_SUM: result_o = sum_i;
         SEL_LT:  result_o = {{(WIDTH-1){1'b0}}, lt_bit};
         default: result_o = '0;
      endcase
   end
endmodule

// File: rtl/inv_ctl_alu.sv
module inv_ctl_alu
   import alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int RIPPLE = 0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       ctrl_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             ovf_o
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("inv_ctl_alu: WIDTH must be at least 2");
      end
      if (RIPPLE != 0 && RIPPLE != 1) begin : g_bad_kind
         $error("inv_ctl_alu: RIPPLE must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_c, b_c, sum;
   logic             ovf_raw;
   sel_e             sel;

   assign sel = sel_e'(ctrl_i[1:0]);

   alu_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .a_i(a_i), .b_i(b_i), .inv_a_i(ctrl_i[3]), .inv_b_i(ctrl_i[2]),
      .a_o(a_c), .b_o(b_c)
   );

   alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a_i(a_c), .b_i(b_c), .cin_i(ctrl_i[2]), .sum_o(sum), .ovf_o(ovf_raw)
   );

   alu_result_sel #(.WIDTH(WIDTH)) u_sel (
      .a_i(a_c), .b_i(b_c), .sum_i(sum), .ovf_raw_i(ovf_raw),
      .sel_i(sel), .result_o(result_o)
   );

   assign zero_o = ~|result_o;
   assign ovf_o  = is_arith(ctrl_i) & ovf_raw;
endmodule

// File: rtl/inv_ctl_alu_chk.sv
module inv_ctl_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [3:0]       ctrl_i,
   input logic [WIDTH-1:0] result_o,
   input logic             zero_o,
   input logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      // R7
      a_r7_zero_flag: assert (zero_o == (result_o == '0));
      // R9
      a_r9_no_overflow: assert ((ctrl_i == 4'b0010) || (ctrl_i == 4'b0110) || !ovf_o);
      // R6
      a_r6_lt_upper_clear: assert ((ctrl_i[1:0] != 2'b11) || (result_o[MSB:1] == '0));
      // R8 (add)
      a_r8_add_overflow: assert ((ctrl_i != 4'b0010) ||
         (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB]))));
      // R8 (subtract)
      a_r8_sub_overflow: assert ((ctrl_i != 4'b0110) ||
         (ovf_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB]))));
   end
endmodule

bind inv_ctl_alu inv_ctl_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i(a_i), .b_i(b_i), .ctrl_i(ctrl_i),
   .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/test_inv_ctl_alu.sv
module test_inv_ctl_alu;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic [W-1:0] a, b, res;
   logic [3:0]   ctrl;
   logic         zero, ovf;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   inv_ctl_alu #(.WIDTH(W)) i_inv_ctl_alu (
      .a_i(a), .b_i(b), .ctrl_i(ctrl),
      .result_o(res), .zero_o(zero), .ovf_o(ovf)
   );

   function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y, input bit sub);
      longint s;
      s = sub ? longint'($signed(x)) - longint'($signed(y))
              : longint'($signed(x)) + longint'($signed(y));
      return (s > 64'sd2147483647) || (s < -64'sd2147483648);
   endfunction

   // Expected result from the requirement text (R2..R6, R10)
   function automatic logic [W-1:0] exp_res(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W-1:0] xa, yb, s;
      logic         rov;
      case (c)
         4'b0010: return x + y;
         4'b0110: return x - y;
         4'b0000: return x & y;
         4'b0001: return x | y;
         4'b1100: return ~(x | y);
         4'b0111: return {31'b0, ($signed(x) < $signed(y))};
         default: begin
            xa  = c[3] ? ~x : x;
            yb  = c[2] ? ~y : y;
            s   = xa + yb + {31'b0, c[2]};
            rov = (xa[31] == yb[31]) && (s[31] != xa[31]);
            case (c[1:0])
               2'b00:   return xa & yb;
               2'b01:   return xa | yb;
               2'b10:   return s;
               default: return {31'b0, s[31] ^ rov};
            endcase
         end
      endcase
   endfunction

   function automatic logic exp_ovf(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
      if (c == 4'b0010) return add_ovf(x, y, 1'b0);
      if (c == 4'b0110) return add_ovf(x, y, 1'b1);
      return 1'b0;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W-1:0] er;
      @(negedge clk);
      ctrl = c; a = x; b = y;
      #1;
      er = exp_res(c, x, y);
      check({req, " result"}, res, er);
      check("R7 zero", {31'b0, zero}, {31'b0, er == '0});
      check({req, " ovf"}, {31'b0, ovf}, {31'b0, exp_ovf(c, x, y)});
   endtask

   task automatic t_idle;
      #1;
      check("R4 idle result", res, '0);
      check("R7 idle zero", {31'b0, zero}, 32'd1);
   endtask

   task automatic t_add;   // R2, R8
      apply("R2", 4'b0010, 32'd5, 32'd7);
      apply("R2", 4'b0010, 32'hFFFF_FFFF, 32'd1);
      apply("R8", 4'b0010, 32'h7FFF_FFFF, 32'd1);
      apply("R8", 4'b0010, 32'h8000_0000, 32'h8000_0000);
   endtask

   task automatic t_sub;   // R3, R7, R8
      apply("R3", 4'b0110, 32'd10, 32'd3);
      apply("R3", 4'b0110, 32'd3, 32'd10);
      apply("R7", 4'b0110, 32'h1234_5678, 32'h1234_5678);
      apply("R8", 4'b0110, 32'h8000_0000, 32'd1);
      apply("R8", 4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
   endtask

   task automatic t_logic; // R1, R4, R5
      apply("R4", 4'b0000, 32'hF0F0_1234, 32'hFF00_00FF);
      apply("R4", 4'b0001, 32'hF0F0_1234, 32'h0F00_00FF);
      apply("R5", 4'b1100, 32'hF0F0_1234, 32'h0F00_00FF);
      apply("R5", 4'b1100, 32'h0, 32'h0);
      apply("R1", 4'b0000, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
   endtask

   task automatic t_lt;    // R6
      apply("R6", 4'b0111, 32'hFFFF_FFFF, 32'd1);
      apply("R6", 4'b0111, 32'd1, 32'hFFFF_FFFF);
      apply("R6", 4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
      apply("R6", 4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
      apply("R6", 4'b0111, 32'd9, 32'd9);
   endtask

   task automatic t_unlisted; // R9, R10
      for (int c = 0; c < 16; c++) begin
         apply("R10", 4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
         apply("R9", 4'(c), 32'h8000_0000, 32'h0000_0001);
      end
   endtask

   task automatic t_random;
      logic [W-1:0] s = 32'hACE1_2345;
      logic [W-1:0] x;
      for (int n = 0; n < 300; n++) begin
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         x = s;
         s ^= s << 13; s ^= s >> 17; s ^= s << 5;
         apply("R10", 4'(n % 16), x, (n % 7 == 0) ? x : s);
      end
   endtask

   initial begin
      ctrl = 4'b0000; a = '0; b = '0;
      t_idle();
      t_add();
      t_sub();
      t_logic();
      t_lt();
      t_unlisted();
      t_random();
      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 20000; k++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule